// File: doc/BRIEF.md
# Quad pulse-density DAC modulator

This block turns four 16-bit output words into four one-bit pulse-density streams. Each word carries a 10-bit code in its upper bits. Every channel runs a first-order accumulator on the modulator clock, and the accumulator's carry becomes the output bit. The ones are therefore spread as evenly as a single bit allows, instead of being grouped into one burst per period. An external RC filter turns each stream into a level of roughly reference × code / 1024.

Each channel has its own polarity bit, which inverts the transfer function. A single soft-disable input, shared by all channels, parks every output at its own polarity level. The accumulators keep running while the outputs are parked, so re-enabling a channel needs no resynchronisation.

Top module: `pdm_quad_dac`

## Requirements
- R1: A channel's code is bits 15:6 of its 16-bit word. Bits 5:0 have no effect on the output stream.
- R2: With polarity 0 and soft-disable low, any 1024 consecutive clocks with a constant code contain exactly `code` ones. Code 0 gives a constant 0. Code 3FFh gives 1023 ones.
- R3: With polarity 1 and soft-disable low, any 1024 consecutive clocks with a constant code contain exactly 1023 − code ones. Code 3FFh gives a constant 0 and code 0 gives 1023 ones.
- R4: While soft-disable is high, each output equals its channel's polarity bit, starting with the first clock edge that samples soft-disable high.
- R5: When the effective code (the ones count of R2/R3) is at most 512, no two consecutive output bits are both 1. When it is at least 512, no two consecutive output bits are both 0.
- R6: Reset clears every output and accumulator to zero. After reset, the first n clocks with effective code e produce exactly floor(n·e/1024) ones.
- R7: A new code or polarity takes effect on the next clock edge and does not clear the accumulator. The 1024 clocks that start with that edge already contain the new ones count exactly.
- R8: The channels are independent: each stream depends only on its own word and polarity bit and on the shared soft-disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| value_i | input | NUM_CH*16 | Per-channel 16-bit words; channel c occupies bits [16c+15:16c] |
| pol_i | input | NUM_CH | Per-channel polarity; 1 inverts the transfer function |
| soft_off_i | input | 1 | Shared soft-disable; holds every output at its polarity level |
| pdm_o | output | NUM_CH | Pulse-density output bits, one per channel |

## Verification
The assertions assume that the words, polarity bits and soft-disable are synchronous to the modulator clock and are sampled only at its rising edge. The spreading checks of R5 apply only while a channel's code and polarity have been held for two edges in a row. The bench meets these assumptions by changing every input just after a falling edge and holding it for a full 1024-clock window. It then compares the counts of ones, and the runs of equal bits, with values it computes arithmetically from the requirements.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;
  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_VAL_W  = 16;
  localparam int unsigned DEF_CODE_W = 10;

  // number of clocks in one full modulation period
  function automatic int unsigned period_len(input int unsigned code_w);
    return 32'd1 << code_w;
  endfunction
endpackage

// File: rtl/pdm_code_map.sv
module pdm_code_map #(
  parameter int unsigned VAL_W  = 16,
  parameter int unsigned CODE_W = 10
) (
  input  logic [VAL_W-1:0]  value_i,
  input  logic              pol_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned LSB_W = VAL_W - CODE_W;

  // inverting the code gives (2^W - 1 - code) ones per period
  assign code_o = value_i[VAL_W-1 -: CODE_W] ^ {CODE_W{pol_i}};

  generate
    if (LSB_W > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^value_i[LSB_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pdm_accum.sv
module pdm_accum #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              carry_o
);
  logic [CODE_W-1:0] acc_q;
  logic [CODE_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, code_i};
  assign carry_o = sum[CODE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[CODE_W-1:0];
  end
endmodule

// File: rtl/pdm_out_stage.sv
module pdm_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carry_i,
  input  logic pol_i,
  input  logic force_i,
  output logic pdm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pdm_o <= 1'b0;
    else if (force_i) pdm_o <= pol_i;
    else              pdm_o <= carry_i;
  end
endmodule

// File: rtl/pdm_quad_dac.sv
module pdm_quad_dac #(
  parameter int unsigned NUM_CH = pdm_dac_pkg::DEF_NUM_CH,
  parameter int unsigned VAL_W  = pdm_dac_pkg::DEF_VAL_W,
  parameter int unsigned CODE_W = pdm_dac_pkg::DEF_CODE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*VAL_W-1:0] value_i,
  input  logic [NUM_CH-1:0]       pol_i,
  input  logic                    soft_off_i,
  output logic [NUM_CH-1:0]       pdm_o
);
  logic [NUM_CH-1:0] carry;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] eff_code;

    pdm_code_map #(.VAL_W(VAL_W), .CODE_W(CODE_W)) u_map (
      .value_i (value_i[c*VAL_W +: VAL_W]),
      .pol_i   (pol_i[c]),
      .code_o  (eff_code)
    );

    pdm_accum #(.CODE_W(CODE_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .code_i  (eff_code),
      .carry_o (carry[c])
    );

    pdm_out_stage u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .carry_i (carry[c]),
      .pol_i   (pol_i[c]),
      .force_i (soft_off_i),
      .pdm_o   (pdm_o[c])
    );
  end
endmodule

// File: rtl/pdm_quad_dac_chk.sv
module pdm_quad_dac_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned VAL_W  = 16,
  parameter int unsigned CODE_W = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH*VAL_W-1:0] value_i,
  input logic [NUM_CH-1:0]       pol_i,
  input logic                    soft_off_i,
  input logic [NUM_CH-1:0]       pdm_o
);
  localparam logic [CODE_W-1:0] HALF = CODE_W'(1) << (CODE_W-1);

  logic [NUM_CH-1:0][CODE_W-1:0] eff;
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      eff[c] = pol_i[c] ? ~value_i[c*VAL_W+VAL_W-1 -: CODE_W]
                        :  value_i[c*VAL_W+VAL_W-1 -: CODE_W];
    end
  end

  // R6
  reset_idle_chk: assert property (@(posedge clk_i) $rose(rst_ni) |-> pdm_o == '0);

  // R4
  soft_off_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_off_i |=> pdm_o == $past(pol_i));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2 R3
    zero_code_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!soft_off_i && eff[c] == '0) |=> !pdm_o[c]);

    // R5
    sparse_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !soft_off_i && !$past(soft_off_i) && $stable(eff[c])
       && eff[c] <= HALF && pdm_o[c]) |=> !pdm_o[c]);

    // R5
    dense_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !soft_off_i && !$past(soft_off_i) && $stable(eff[c])
       && eff[c] >= HALF && !pdm_o[c]) |=> pdm_o[c]);
  end
endmodule

bind pdm_quad_dac pdm_quad_dac_chk #(
  .NUM_CH(NUM_CH), .VAL_W(VAL_W), .CODE_W(CODE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .value_i    (value_i),
  .pol_i      (pol_i),
  .soft_off_i (soft_off_i),
  .pdm_o      (pdm_o)
);

// File: tb/pdm_quad_dac_tb.sv
module pdm_quad_dac_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int VAL_W  = 16;
  localparam int CODE_W = 10;
  localparam int WIN    = 1024;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NUM_CH*VAL_W-1:0] value = '0;
  logic [NUM_CH-1:0] pol = '0;
  logic soft_off = 1'b0;
  logic [NUM_CH-1:0] pdm;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_quad_dac #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .CODE_W(CODE_W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .value_i    (value),
    .pol_i      (pol),
    .soft_off_i (soft_off),
    .pdm_o      (pdm)
  );

  task automatic chk(input string req, input int ch, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d", req, ch, act, exp);
    end
  endtask

  task automatic set_ch(input int c, input int code, input int low, input bit p);
    logic [CODE_W-1:0] cd;
    logic [VAL_W-CODE_W-1:0] lo;
    cd = code[CODE_W-1:0];
    lo = low[VAL_W-CODE_W-1:0];
    value[c*VAL_W +: VAL_W] = {cd, lo};
    pol[c] = p;
  endtask

  function automatic int eff_of(input int c);
    int code;
    code = int'(value[c*VAL_W+VAL_W-CODE_W +: CODE_W]);
    return pol[c] ? (WIN - 1 - code) : code;
  endfunction

  task automatic run_window(input string req);
    int ones [NUM_CH];
    int dbl1 [NUM_CH];
    int dbl0 [NUM_CH];
    logic [NUM_CH-1:0] prev;
    prev = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      ones[c] = 0; dbl1[c] = 0; dbl0[c] = 0;
    end
    for (int n = 0; n < WIN; n++) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) begin
        ones[c] += int'(pdm[c]);
        if (n > 0 && pdm[c] && prev[c]) dbl1[c]++;
        if (n > 0 && !pdm[c] && !prev[c]) dbl0[c]++;
      end
      prev = pdm;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (soft_off) begin
        chk("R4", c, ones[c], pol[c] ? WIN : 0);
      end else begin
        chk(req, c, ones[c], eff_of(c));
        if (eff_of(c) <= WIN/2) chk("R5 no double one", c, dbl1[c], 0);
        if (eff_of(c) >= WIN/2) chk("R5 no double zero", c, dbl0[c], 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ones [NUM_CH];
    // R6: reset state
    set_ch(0, 300, 0, 1'b0);
    set_ch(1, 1, 63, 1'b0);
    set_ch(2, 1023, 0, 1'b1);
    set_ch(3, 0, 21, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6 reset output", 0, int'(pdm), 0);
    rst_ni = 1'b1;
    for (int c = 0; c < NUM_CH; c++) ones[c] = 0;
    for (int n = 1; n <= WIN; n++) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) ones[c] += int'(pdm[c]);
      if (n == 100 || n == 517 || n == WIN) begin
        for (int c = 0; c < NUM_CH; c++)
          chk("R6 prefix after reset", c, ones[c], (n * eff_of(c)) / WIN);
      end
    end

    // R2 corners, polarity 0; R7 new codes counted from the next edge
    set_ch(0, 0, 5, 1'b0);    set_ch(1, 1023, 0, 1'b0);
    set_ch(2, 512, 63, 1'b0); set_ch(3, 511, 1, 1'b0);
    run_window("R2 R7");
    // R3 corners, polarity 1
    set_ch(0, 1023, 7, 1'b1); set_ch(1, 0, 0, 1'b1);
    set_ch(2, 511, 2, 1'b1);  set_ch(3, 513, 40, 1'b1);
    run_window("R3 R7");
    // R1: same codes, different low bits
    set_ch(0, 1023, 63, 1'b1); set_ch(1, 0, 62, 1'b1);
    set_ch(2, 511, 33, 1'b1);  set_ch(3, 513, 0, 1'b1);
    run_window("R1");

    // R4: soft-disable parks outputs at polarity level
    set_ch(0, 700, 0, 1'b1); set_ch(1, 700, 0, 1'b0);
    set_ch(2, 3, 0, 1'b1);   set_ch(3, 1020, 0, 1'b0);
    soft_off = 1'b1;
    run_window("R4");
    pol = ~pol;
    run_window("R4");
    soft_off = 1'b0;
    run_window("R4 R7 release");

    // R8 sweep: distinct codes, polarities and low bits per channel
    for (int w = 0; w < 40; w++) begin
      for (int c = 0; c < NUM_CH; c++)
        set_ch(c, (w * 97 + c * 263 + 11) % WIN, w * 13 + c, bit'((w + c) % 2));
      run_window("R8 R2 R3 R7");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule